// File: doc/BRIEF.md
# Windowed Watchdog Reset Supervisor

This block watches a single trigger line driven by a host controller and checks that it toggles inside a timing window. Both rising and falling transitions count as triggers. After each reset pulse ends, the host has a long deadline for its first transition. After that, each transition must fall inside a minimum–maximum window measured from the previous one. A transition that is too early, or one that never comes, starts a reset pulse. The width of that pulse is chosen by a two-bit select. All timing is counted in ticks of a one-millisecond enable pulse, so the block runs on any clock that carries that tick.

A second supervision path catches a host that ignores a pending change indication. While the change flag is high, a host read must occur between two accepted triggers. If it does not, a reset pulse is produced and a separate status bit is set. Each path has its own saturating failure counter. When either counter reaches its limit, the block drives its power-off request high and pulses a standby request for one cycle.

A mode-entry strobe from the surrounding mode controller clears both counters, both status flags and the power-off request. Dropping the enable input, as happens in standby or while the undervoltage timer runs, parks the supervisor and discards its timing state.

Top module: `wdsup_top`

## Requirements
- R1: With the supervisor enabled and no transition seen yet (after enable rises or after a reset pulse ends), a transition is accepted while at most FIRST_MS ticks have passed; if none arrives, a watchdog failure occurs on tick FIRST_MS+1.
- R2: After an accepted transition (rising or falling), the next one is accepted when between WIN_MIN_MS and WIN_MAX_MS ticks (inclusive) have passed; if none has arrived, a watchdog failure occurs on tick WIN_MAX_MS+1.
- R3: A transition arriving after fewer than WIN_MIN_MS ticks is a watchdog failure. Every reset pulse has a cause: a watchdog failure sets stat_wd_fail and starts a reset pulse in the next cycle. The flag holds until host_read or mode_entry.
- R4: The reset pulse width is latched from pw_sel when the pulse starts: 2'b00 gives PW0_MS (default 20) ticks, 2'b01 gives PW1_MS (10), 2'b10 gives PW2_MS (5) and 2'b11 gives PW3_MS (1). When the pulse ends, the first-transition deadline of R1 starts.
- R5: The failure that brings either counter to FAIL_LIMIT (default 5) sets pwr_off_req and pulses standby_req for exactly one cycle. pwr_off_req then holds until mode_entry.
- R6: If chg_flag is high when a transition inside the window is accepted, and no host_read occurred since the previous accepted transition, this is a read miss. A read miss starts a reset pulse, sets stat_read_miss and increments miss_errs. A host_read in between avoids the miss.
- R7: A mode_entry strobe clears wd_errs, miss_errs, pwr_off_req and both status flags in the next cycle.
- R8: Each failure raises its own counter by exactly one, and the counter saturates at FAIL_LIMIT.
- R9: While wd_en is low, rst_pulse stays low, transitions are ignored, and the timing state restarts from R1 when wd_en rises.
- R10: After reset, rst_pulse, both status flags, pwr_off_req, standby_req and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| wd_en | input | 1 | Supervisor enable (run mode and undervoltage timer idle) |
| mode_entry | input | 1 | Strobe on entry to run or standby mode; clears counters |
| trig_in | input | 1 | Host trigger line, asynchronous |
| pw_sel | input | 2 | Reset pulse width select |
| host_read | input | 1 | Strobe marking a completed host read |
| chg_flag | input | 1 | Change indication currently pending |
| rst_pulse | output | 1 | Reset pulse to the host |
| stat_wd_fail | output | 1 | Sticky flag: watchdog failure |
| stat_read_miss | output | 1 | Sticky flag: missed host read |
| pwr_off_req | output | 1 | Drive the controlled power output off |
| standby_req | output | 1 | One-cycle standby request |
| wd_errs | output | $clog2(FAIL_LIMIT+1) | Watchdog failure count |
| miss_errs | output | $clog2(FAIL_LIMIT+1) | Read-miss failure count |

## Verification
The bench shortens the time parameters so every window can be walked tick by tick. It uses a 20-tick first deadline, an 8 to 12 tick window and pulse widths of 8, 4, 2 and 1, with one tick every ten clocks. With these values, every exact boundary is reachable in a short run: acceptance at the last allowed tick, failure one tick later, an early trigger one tick before the window opens, and each of the four pulse-width codes. FAIL_LIMIT stays at its default of 5, so the run reaches saturation and checks the standby request at the real count.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_PULSE = 2'd1,
      WS_FIRST = 2'd2,
      WS_WIN   = 2'd3
   } wd_state_e;

   typedef struct packed {
      logic read_miss;
      logic wd_fail;
   } fail_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wdsup_edge.sv
module wdsup_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic edge_p
);
   logic level;
   logic level_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign level = d;
      end else begin : g_sync
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], d};
         end
         assign level = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign edge_p = level ^ level_q;
endmodule

// File: rtl/wdsup_window.sv
module wdsup_window
   import wdsup_pkg::*;
#(
   parameter int FIRST_MS   = 500,
   parameter int WIN_MIN_MS = 200,
   parameter int WIN_MAX_MS = 300,
   parameter int PW0_MS     = 20,
   parameter int PW1_MS     = 10,
   parameter int PW2_MS     = 5,
   parameter int PW3_MS     = 1,
   parameter int CW         = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       trig_edge,
   input  logic [1:0] pw_sel,
   input  logic       host_read,
   input  logic       chg_flag,
   output logic       pulse,
   output fail_t      fail
);
   localparam logic [CW-1:0] K_FIRST = CW'(FIRST_MS);
   localparam logic [CW-1:0] K_MIN   = CW'(WIN_MIN_MS);
   localparam logic [CW-1:0] K_MAX   = CW'(WIN_MAX_MS);

   wd_state_e     state, nstate;
   logic [CW-1:0] cnt, ncnt;
   logic [CW-1:0] pw_len, npw;
   logic          seen;
   logic          accept;

   function automatic logic [CW-1:0] len_of(input logic [1:0] s);
      case (s)
         2'b00:   return CW'(PW0_MS);
         2'b01:   return CW'(PW1_MS);
         2'b10:   return CW'(PW2_MS);
         default: return CW'(PW3_MS);
      endcase
   endfunction

   always_comb begin
      nstate = state;
      ncnt   = cnt;
      npw    = pw_len;
      fail   = '0;
      accept = 1'b0;
      unique case (state)
         WS_IDLE: begin
            nstate = WS_FIRST;
            ncnt   = '0;
         end
         WS_PULSE: begin
            if (tick) begin
               if (cnt == pw_len - CW'(1)) begin
                  nstate = WS_FIRST;
                  ncnt   = '0;
               end else begin
                  ncnt = cnt + CW'(1);
               end
            end
         end
         WS_FIRST: begin
            if (trig_edge) begin
               accept = 1'b1;
               nstate = WS_WIN;
               ncnt   = '0;
            end else if (tick) begin
               if (cnt == K_FIRST) fail.wd_fail = 1'b1;
               else                ncnt = cnt + CW'(1);
            end
         end
         WS_WIN: begin
            if (trig_edge) begin
               if (cnt < K_MIN)               fail.wd_fail   = 1'b1;
               else if (chg_flag && !seen)    fail.read_miss = 1'b1;
               else begin
                  accept = 1'b1;
                  ncnt   = '0;
               end
            end else if (tick) begin
               if (cnt == K_MAX) fail.wd_fail = 1'b1;
               else              ncnt = cnt + CW'(1);
            end
         end
      endcase
      if (fail.wd_fail || fail.read_miss) begin
         nstate = WS_PULSE;
         ncnt   = '0;
         npw    = len_of(pw_sel);
      end
      if (!en) begin
         nstate = WS_IDLE;
         ncnt   = '0;
         fail   = '0;
         accept = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= WS_IDLE;
         cnt    <= '0;
         pw_len <= CW'(PW0_MS);
         seen   <= 1'b0;
      end else begin
         state  <= nstate;
         cnt    <= ncnt;
         pw_len <= npw;
         if (!en || accept) seen <= host_read;
         else if (host_read) seen <= 1'b1;
      end
   end

   assign pulse = (state == WS_PULSE);
endmodule

// File: rtl/wdsup_errcnt.sv
module wdsup_errcnt #(
   parameter int LIMIT = 5,
   parameter int ECW   = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           inc,
   output logic [ECW-1:0] count,
   output logic           hit
);
   localparam logic [ECW-1:0] K_LIM = ECW'(LIMIT);

   assign hit = inc && !clr && (count == K_LIM - ECW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count <= '0;
      else if (clr)                    count <= '0;
      else if (inc && count != K_LIM)  count <= count + ECW'(1);
   end
endmodule

// File: rtl/wdsup_top.sv
module wdsup_top
   import wdsup_pkg::*;
#(
   parameter int FIRST_MS    = 500,
   parameter int WIN_MIN_MS  = 200,
   parameter int WIN_MAX_MS  = 300,
   parameter int PW0_MS      = 20,
   parameter int PW1_MS      = 10,
   parameter int PW2_MS      = 5,
   parameter int PW3_MS      = 1,
   parameter int FAIL_LIMIT  = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick_ms,
   input  logic                            wd_en,
   input  logic                            mode_entry,
   input  logic                            trig_in,
   input  logic [1:0]                      pw_sel,
   input  logic                            host_read,
   input  logic                            chg_flag,
   output logic                            rst_pulse,
   output logic                            stat_wd_fail,
   output logic                            stat_read_miss,
   output logic                            pwr_off_req,
   output logic                            standby_req,
   output logic [$clog2(FAIL_LIMIT+1)-1:0] wd_errs,
   output logic [$clog2(FAIL_LIMIT+1)-1:0] miss_errs
);
   localparam int ECW    = $clog2(FAIL_LIMIT + 1);
   localparam int PW_MAX = max_of(max_of(PW0_MS, PW1_MS), max_of(PW2_MS, PW3_MS));
   localparam int T_MAX  = max_of(max_of(FIRST_MS, WIN_MAX_MS), PW_MAX);
   localparam int CW     = $clog2(T_MAX + 2);

   generate
      if (WIN_MIN_MS < 1 || WIN_MIN_MS > WIN_MAX_MS) begin : g_bad_win
         $error("wdsup_top: window bounds out of order");
      end
      if (PW0_MS < 1 || PW1_MS < 1 || PW2_MS < 1 || PW3_MS < 1) begin : g_bad_pw
         $error("wdsup_top: pulse widths must be at least one tick");
      end
      if (FAIL_LIMIT < 1 || FIRST_MS < 1) begin : g_bad_lim
         $error("wdsup_top: limit and first deadline must be positive");
      end
   endgenerate

   logic           trig_edge;
   fail_t          fail;
   logic [1:0]     inc_v;
   logic [1:0]     hit_v;
   logic [ECW-1:0] cnt_v [2];

   wdsup_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (trig_in),
      .edge_p (trig_edge)
   );

   wdsup_window #(
      .FIRST_MS   (FIRST_MS),
      .WIN_MIN_MS (WIN_MIN_MS),
      .WIN_MAX_MS (WIN_MAX_MS),
      .PW0_MS     (PW0_MS),
      .PW1_MS     (PW1_MS),
      .PW2_MS     (PW2_MS),
      .PW3_MS     (PW3_MS),
      .CW         (CW)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_ms),
      .en        (wd_en),
      .trig_edge (trig_edge),
      .pw_sel    (pw_sel),
      .host_read (host_read),
      .chg_flag  (chg_flag),
      .pulse     (rst_pulse),
      .fail      (fail)
   );

   assign inc_v = {fail.read_miss, fail.wd_fail};

   for (genvar g = 0; g < 2; g++) begin : g_cnt
      wdsup_errcnt #(.LIMIT(FAIL_LIMIT), .ECW(ECW)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (mode_entry),
         .inc   (inc_v[g]),
         .count (cnt_v[g]),
         .hit   (hit_v[g])
      );
   end

   assign wd_errs   = cnt_v[0];
   assign miss_errs = cnt_v[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_wd_fail   <= 1'b0;
         stat_read_miss <= 1'b0;
         pwr_off_req    <= 1'b0;
         standby_req    <= 1'b0;
      end else begin
         if (fail.wd_fail)                 stat_wd_fail <= 1'b1;
         else if (host_read || mode_entry) stat_wd_fail <= 1'b0;
         if (fail.read_miss)               stat_read_miss <= 1'b1;
         else if (host_read || mode_entry) stat_read_miss <= 1'b0;
         if (mode_entry)                   pwr_off_req <= 1'b0;
         else if (|hit_v)                  pwr_off_req <= 1'b1;
         standby_req <= |hit_v;
      end
   end
endmodule

// File: rtl/wdsup_chk.sv
module wdsup_chk #(
   parameter int FAIL_LIMIT = 5,
   parameter int ECW        = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wd_en,
   input logic           mode_entry,
   input logic           rst_pulse,
   input logic           stat_wd_fail,
   input logic           stat_read_miss,
   input logic           pwr_off_req,
   input logic           standby_req,
   input logic [ECW-1:0] wd_errs,
   input logic [ECW-1:0] miss_errs
);
   localparam logic [ECW-1:0] K_LIM = ECW'(FAIL_LIMIT);

   a_r8_counts_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_errs <= K_LIM) && (miss_errs <= K_LIM));

   a_r8_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_errs != $past(wd_errs)) |-> (wd_errs == $past(wd_errs) + ECW'(1)) || (wd_errs == '0));

   a_r5_limit_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_errs == K_LIM || miss_errs == K_LIM) |-> pwr_off_req);

   a_r5_standby_with_off: assert property (@(posedge clk) disable iff (!rst_n)
      standby_req |-> pwr_off_req);

   a_r5_standby_single: assert property (@(posedge clk) disable iff (!rst_n)
      standby_req |=> !standby_req);

   a_r7_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
      mode_entry |=> (wd_errs == '0) && (miss_errs == '0) && !pwr_off_req);

   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_en |=> !rst_pulse);

   a_r3_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_pulse) |-> (stat_wd_fail || stat_read_miss));
endmodule

bind wdsup_top wdsup_chk #(.FAIL_LIMIT(FAIL_LIMIT), .ECW($clog2(FAIL_LIMIT+1))) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wd_en          (wd_en),
   .mode_entry     (mode_entry),
   .rst_pulse      (rst_pulse),
   .stat_wd_fail   (stat_wd_fail),
   .stat_read_miss (stat_read_miss),
   .pwr_off_req    (pwr_off_req),
   .standby_req    (standby_req),
   .wd_errs        (wd_errs),
   .miss_errs      (miss_errs)
);

// File: tb/wdsup_top_tb.sv
module wdsup_top_tb;
   localparam int FIRST = 20;
   localparam int WMIN  = 8;
   localparam int WMAX  = 12;
   localparam int PWA   = 8;
   localparam int PWB   = 4;
   localparam int PWC   = 2;
   localparam int PWD   = 1;
   localparam int LIM   = 5;
   localparam int ECW   = $clog2(LIM + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_ms = 1'b0;
   logic wd_en = 1'b0;
   logic mode_entry = 1'b0;
   logic trig_in = 1'b0;
   logic [1:0] pw_sel = 2'b00;
   logic host_read = 1'b0;
   logic chg_flag = 1'b0;
   logic rst_pulse, stat_wd_fail, stat_read_miss, pwr_off_req, standby_req;
   logic [ECW-1:0] wd_errs, miss_errs;

   int checks = 0;
   int fails = 0;
   int tdiv = 0;
   int rises = 0;
   int sb_count = 0;
   logic pr_q = 1'b0;
   bit done = 0;

   always #2 clk = ~clk;

   wdsup_top #(
      .FIRST_MS(FIRST), .WIN_MIN_MS(WMIN), .WIN_MAX_MS(WMAX),
      .PW0_MS(PWA), .PW1_MS(PWB), .PW2_MS(PWC), .PW3_MS(PWD),
      .FAIL_LIMIT(LIM), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wd_en(wd_en),
      .mode_entry(mode_entry), .trig_in(trig_in), .pw_sel(pw_sel),
      .host_read(host_read), .chg_flag(chg_flag), .rst_pulse(rst_pulse),
      .stat_wd_fail(stat_wd_fail), .stat_read_miss(stat_read_miss),
      .pwr_off_req(pwr_off_req), .standby_req(standby_req),
      .wd_errs(wd_errs), .miss_errs(miss_errs)
   );

   always @(negedge clk) begin
      if (!rst_n) begin
         tdiv    <= 0;
         tick_ms <= 1'b0;
      end else begin
         tdiv    <= (tdiv == 9) ? 0 : tdiv + 1;
         tick_ms <= (tdiv == 9);
      end
   end

   always @(posedge clk) begin
      pr_q <= rst_pulse;
      if (rst_pulse && !pr_q) rises <= rises + 1;
      if (standby_req) sb_count <= sb_count + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         do @(posedge clk); while (!tick_ms);
      end
   endtask

   task automatic toggle_trig();
      @(negedge clk) trig_in = ~trig_in;
   endtask

   task automatic strobe_read();
      @(negedge clk) host_read = 1'b1;
      @(negedge clk) host_read = 1'b0;
   endtask

   task automatic ticks_to_rise(output int n);
      n = 0;
      for (int i = 0; i < 2000; i++) begin
         @(posedge clk);
         if (tick_ms) n++;
         #1;
         if (rst_pulse) break;
      end
   endtask

   task automatic pulse_width(output int n);
      n = 0;
      for (int i = 0; i < 2000; i++) begin
         @(posedge clk);
         if (tick_ms) n++;
         #1;
         if (!rst_pulse) break;
      end
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk(rst_pulse == 0, "R10 rst_pulse", int'(rst_pulse), 0);
      chk(stat_wd_fail == 0 && stat_read_miss == 0, "R10 status", int'(stat_wd_fail) + int'(stat_read_miss), 0);
      chk(pwr_off_req == 0 && standby_req == 0, "R10 power", int'(pwr_off_req), 0);
      chk(wd_errs == 0 && miss_errs == 0, "R10 counters", int'(wd_errs), 0);
   endtask

   task automatic t_first_deadline();
      int n;
      wait_ticks(1);
      @(negedge clk) wd_en = 1'b1;
      ticks_to_rise(n);
      chk(n == FIRST + 1, "R1 first deadline tick", n, FIRST + 1);
      chk(stat_wd_fail == 1, "R3 status set", int'(stat_wd_fail), 1);
      chk(wd_errs == 1, "R8 count one", int'(wd_errs), 1);
      pulse_width(n);
      chk(n == PWA, "R4 width code 00", n, PWA);
   endtask

   task automatic t_good_windows();
      int r0;
      strobe_read();
      #1;
      chk(stat_wd_fail == 0, "R3 status cleared by read", int'(stat_wd_fail), 0);
      r0 = rises;
      wait_ticks(FIRST - 1); toggle_trig();
      wait_ticks(WMIN);      toggle_trig();
      wait_ticks(WMAX);      toggle_trig();
      wait_ticks(WMIN + 1);  toggle_trig();
      settle();
      chk(rises == r0 && rst_pulse == 0, "R2 in-window triggers accepted", rises - r0, 0);
      chk(wd_errs == 1, "R2 no new failure", int'(wd_errs), 1);
   endtask

   task automatic t_early();
      int n;
      pw_sel = 2'b01;
      wait_ticks(WMIN - 1 - 0); toggle_trig();
      ticks_to_rise(n);
      chk(n == 0, "R3 early trigger fails at once", n, 0);
      chk(wd_errs == 2 && stat_wd_fail == 1, "R3 early counted", int'(wd_errs), 2);
      pulse_width(n);
      chk(n == PWB, "R4 width code 01", n, PWB);
   endtask

   task automatic t_late();
      int n;
      pw_sel = 2'b10;
      wait_ticks(3); toggle_trig();
      ticks_to_rise(n);
      chk(n == WMAX + 1, "R2 late deadline tick", n, WMAX + 1);
      chk(wd_errs == 3, "R8 count three", int'(wd_errs), 3);
      pulse_width(n);
      chk(n == PWC, "R4 width code 10", n, PWC);
   endtask

   task automatic t_read_miss();
      int n;
      pw_sel = 2'b11;
      strobe_read();
      chg_flag = 1'b1;
      wait_ticks(2);    toggle_trig();
      wait_ticks(WMIN); toggle_trig();
      ticks_to_rise(n);
      chk(n == 0, "R6 miss pulse at trigger", n, 0);
      chk(stat_read_miss == 1 && stat_wd_fail == 0, "R6 miss status", int'(stat_read_miss), 1);
      chk(miss_errs == 1 && wd_errs == 3, "R6 miss counted", int'(miss_errs), 1);
      pulse_width(n);
      chk(n == PWD, "R4 width code 11", n, PWD);
   endtask

   task automatic t_read_ok();
      int r0;
      r0 = rises;
      wait_ticks(2); toggle_trig();
      wait_ticks(3); strobe_read();
      wait_ticks(WMIN - 3); toggle_trig();
      settle();
      chk(rises == r0, "R6 read between triggers avoids miss", rises - r0, 0);
      chk(miss_errs == 1, "R6 miss count unchanged", int'(miss_errs), 1);
      chg_flag = 1'b0;
   endtask

   task automatic t_disabled();
      int r0;
      @(negedge clk) wd_en = 1'b0;
      r0 = rises;
      for (int i = 0; i < 6; i++) begin
         wait_ticks(7); toggle_trig();
      end
      wait_ticks(30);
      #1;
      chk(rises == r0 && rst_pulse == 0, "R9 no pulse while disabled", rises - r0, 0);
      chk(wd_errs == 3, "R9 no failures while disabled", int'(wd_errs), 3);
   endtask

   task automatic t_saturate();
      int n;
      int s0;
      s0 = sb_count;
      wait_ticks(1);
      @(negedge clk) wd_en = 1'b1;
      ticks_to_rise(n);
      chk(n == FIRST + 1, "R9 restart uses first deadline", n, FIRST + 1);
      pulse_width(n);
      chk(wd_errs == 4 && pwr_off_req == 0, "R5 below limit", int'(wd_errs), 4);
      ticks_to_rise(n);
      pulse_width(n);
      chk(wd_errs == LIM, "R5 reached limit", int'(wd_errs), LIM);
      chk(pwr_off_req == 1, "R5 power off", int'(pwr_off_req), 1);
      chk(sb_count - s0 == 1, "R5 one standby pulse", sb_count - s0, 1);
      ticks_to_rise(n);
      pulse_width(n);
      chk(wd_errs == LIM, "R8 saturates", int'(wd_errs), LIM);
      chk(sb_count - s0 == 1 && pwr_off_req == 1, "R5 no repeat standby", sb_count - s0, 1);
   endtask

   task automatic t_mode_entry();
      @(negedge clk) mode_entry = 1'b1;
      @(negedge clk) mode_entry = 1'b0;
      #1;
      chk(wd_errs == 0 && miss_errs == 0, "R7 counters cleared", int'(wd_errs) + int'(miss_errs), 0);
      chk(pwr_off_req == 0, "R7 power request cleared", int'(pwr_off_req), 0);
      chk(stat_wd_fail == 0 && stat_read_miss == 0, "R7 status cleared", int'(stat_wd_fail), 0);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_first_deadline();
      t_good_windows();
      t_early();
      t_late();
      t_read_miss();
      t_read_ok();
      t_disabled();
      t_saturate();
      t_mode_entry();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule